// File: doc/BRIEF.md
# Downward-Growing Hardware Stack Pointer

This unit keeps a 16-bit stack pointer that holds an address in data space. It drives one data memory port, with address, write data, write enable and read enable, and it moves bytes between that port and the rest of the core. A single-byte push stores a byte and a single-byte pop loads one. A call or interrupt entry saves a 16-bit return address as two bytes. A subroutine or interrupt return loads those two bytes back. The stack grows toward lower addresses. A push stores at the current pointer and then moves the pointer down. A pop first moves the pointer up and then reads from the new address.

Software sees the pointer as two byte-wide registers, one low and one high, and can write either of them. Before the stack is used, software must place the pointer above the register and I/O region, at 0x60 or higher. A sticky flag reports any stack write that lands at or below 0x5F. The program counter and the interrupt controller sit outside this block. They supply the return address and take back the restored one.

The memory port reads combinationally: `mem_rdata_i` must reflect `mem_addr_o` within the same cycle.

Top module: `stack_ptr_unit`

## Requirements
- R1: After reset the pointer is 0x0000, and `busy_o`, `stk_err_o`, `pop_valid_o` and `ret_valid_o` are all 0.
- R2: When the unit is not busy, `sw_wr_lo_i` loads `sw_wdata_i` into pointer bits 7:0 and `sw_wr_hi_i` loads it into bits 15:8. The other byte is kept. The new value appears after the next clock edge. A software write in the same cycle as an operation wins, and the operation is dropped.
- R3: Op code 1 (push) drives a write of `push_data_i` to the current pointer address in that same cycle and lowers the pointer by one.
- R4: Op code 2 (pop) drives a read at pointer+1 and raises the pointer by one. In the following cycle `pop_valid_o` is 1 and `pop_data_o` holds the byte that was read.
- R5: Op code 3 (call or interrupt entry) takes two cycles. The first cycle writes return-address bits 7:0 at the pointer. The second cycle writes bits 15:8 at pointer−1. `busy_o` is high during the second cycle. The pointer ends 2 lower.
- R6: Op code 4 (return) takes two cycles. The first cycle reads the high byte at pointer+1. The second cycle reads the low byte at pointer+2. `busy_o` is high during the second cycle. The pointer ends 2 higher. In the next cycle `ret_valid_o` is 1 and `ret_addr_o` holds the restored address.
- R7: While `busy_o` is 1, both the op code and the software writes are ignored, and busy lasts exactly one cycle.
- R8: `stk_err_o` goes to 1 in the cycle after any stack write to an address at or below 0x5F. It stays at 1 until a software pointer write clears it.
- R9: Op codes 0, 5, 6 and 7 change nothing. Write enable and read enable are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 3 | Stack operation code |
| push_data_i | input | 8 | Byte to push |
| ret_addr_i | input | 16 | Return address to save on call |
| sw_wr_lo_i | input | 1 | Software write to pointer low byte |
| sw_wr_hi_i | input | 1 | Software write to pointer high byte |
| sw_wdata_i | input | 8 | Software write data |
| sp_lo_o | output | 8 | Pointer low byte |
| sp_hi_o | output | 8 | Pointer high byte |
| mem_addr_o | output | 16 | Data memory address |
| mem_wdata_o | output | 8 | Data memory write byte |
| mem_we_o | output | 1 | Data memory write enable |
| mem_re_o | output | 1 | Data memory read enable |
| mem_rdata_i | input | 8 | Data memory read byte (combinational) |
| pop_data_o | output | 8 | Byte returned by last pop |
| pop_valid_o | output | 1 | Pop result valid |
| ret_addr_o | output | 16 | Restored return address |
| ret_valid_o | output | 1 | Restored address valid |
| busy_o | output | 1 | Second cycle of a two-byte transfer |
| stk_err_o | output | 1 | Sticky invalid-stack flag |

## Verification
On every cycle the assertions check the pointer step sizes for each operation and the one-cycle length of busy. They also check that a low-only software write leaves the high byte alone, that the flag rises after a low write, and that write and read enables never overlap. Some behaviour only the bench scenarios can show. That covers the byte order inside a call frame and LIFO data recovery across nested calls and pushes. It also covers ops and software writes dropped during busy, and the flag clearing on a software write. A behavioural model checks the memory port and every output on every clock.

// File: rtl/stk_pkg.sv
package stk_pkg;
    localparam logic [15:0] STK_FLOOR = 16'h005F;

    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } stk_op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_CALL2 = 2'd1,
        PH_RET2  = 2'd2
    } stk_phase_e;
endpackage

// File: rtl/stk_step.sv
module stk_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] sp_i,
    output logic [W-1:0] inc_o,
    output logic [W-1:0] dec_o
);
    assign inc_o = sp_i + W'(1);
    assign dec_o = sp_i - W'(1);
endmodule

// File: rtl/stk_floor_cmp.sv
module stk_floor_cmp #(
    parameter int          W     = 16,
    parameter logic [W-1:0] FLOOR = W'(16'h005F)
) (
    input  logic [W-1:0] addr_i,
    input  logic         we_i,
    output logic         hit_o
);
    assign hit_o = we_i && (addr_i <= FLOOR);
endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
    import stk_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter logic [2*BYTE_W-1:0] FLOOR_ADDR = (2*BYTE_W)'(STK_FLOOR)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2:0]            op_i,
    input  logic [BYTE_W-1:0]     push_data_i,
    input  logic [2*BYTE_W-1:0]   ret_addr_i,
    input  logic                  sw_wr_lo_i,
    input  logic                  sw_wr_hi_i,
    input  logic [BYTE_W-1:0]     sw_wdata_i,
    output logic [BYTE_W-1:0]     sp_lo_o,
    output logic [BYTE_W-1:0]     sp_hi_o,
    output logic [2*BYTE_W-1:0]   mem_addr_o,
    output logic [BYTE_W-1:0]     mem_wdata_o,
    output logic                  mem_we_o,
    output logic                  mem_re_o,
    input  logic [BYTE_W-1:0]     mem_rdata_i,
    output logic [BYTE_W-1:0]     pop_data_o,
    output logic                  pop_valid_o,
    output logic [2*BYTE_W-1:0]   ret_addr_o,
    output logic                  ret_valid_o,
    output logic                  busy_o,
    output logic                  stk_err_o
);
    localparam int SP_W = 2 * BYTE_W;

    typedef struct packed {
        logic [SP_W-1:0]   sp;
        stk_phase_e        phase;
        logic [BYTE_W-1:0] hold;
        logic [BYTE_W-1:0] pop_data;
        logic              pop_valid;
        logic [SP_W-1:0]   ret_addr;
        logic              ret_valid;
        logic              err;
    } stk_state_t;

    stk_state_t r_q, r_d;

    logic [SP_W-1:0]   sp_inc, sp_dec;
    logic [SP_W-1:0]   addr_c;
    logic [BYTE_W-1:0] wdata_c;
    logic              we_c, re_c, low_hit;
    logic              sw_any;
    stk_op_e           op;

    assign op     = stk_op_e'(op_i);
    assign sw_any = sw_wr_lo_i | sw_wr_hi_i;

    stk_step #(.W(SP_W)) u_step (
        .sp_i  (r_q.sp),
        .inc_o (sp_inc),
        .dec_o (sp_dec)
    );

    stk_floor_cmp #(.W(SP_W), .FLOOR(FLOOR_ADDR)) u_floor (
        .addr_i (addr_c),
        .we_i   (we_c),
        .hit_o  (low_hit)
    );

    always_comb begin
        r_d           = r_q;
        r_d.pop_valid = 1'b0;
        r_d.ret_valid = 1'b0;
        we_c          = 1'b0;
        re_c          = 1'b0;
        addr_c        = r_q.sp;
        wdata_c       = '0;

        unique case (r_q.phase)
            PH_IDLE: begin
                if (sw_any) begin
                    if (sw_wr_lo_i) r_d.sp[BYTE_W-1:0]    = sw_wdata_i;
                    if (sw_wr_hi_i) r_d.sp[SP_W-1:BYTE_W] = sw_wdata_i;
                    r_d.err = 1'b0;
                end else begin
                    case (op)
                        OP_PUSH: begin
                            we_c    = 1'b1;
                            wdata_c = push_data_i;
                            r_d.sp  = sp_dec;
                        end
                        OP_POP: begin
                            re_c          = 1'b1;
                            addr_c        = sp_inc;
                            r_d.sp        = sp_inc;
                            r_d.pop_data  = mem_rdata_i;
                            r_d.pop_valid = 1'b1;
                        end
                        OP_CALL: begin
                            we_c      = 1'b1;
                            wdata_c   = ret_addr_i[BYTE_W-1:0];
                            r_d.hold  = ret_addr_i[SP_W-1:BYTE_W];
                            r_d.sp    = sp_dec;
                            r_d.phase = PH_CALL2;
                        end
                        OP_RET: begin
                            re_c      = 1'b1;
                            addr_c    = sp_inc;
                            r_d.hold  = mem_rdata_i;
                            r_d.sp    = sp_inc;
                            r_d.phase = PH_RET2;
                        end
                        default: ;
                    endcase
                end
            end
            PH_CALL2: begin
                we_c      = 1'b1;
                wdata_c   = r_q.hold;
                r_d.sp    = sp_dec;
                r_d.phase = PH_IDLE;
            end
            PH_RET2: begin
                re_c          = 1'b1;
                addr_c        = sp_inc;
                r_d.ret_addr  = {r_q.hold, mem_rdata_i};
                r_d.ret_valid = 1'b1;
                r_d.sp        = sp_inc;
                r_d.phase     = PH_IDLE;
            end
            default: r_d.phase = PH_IDLE;
        endcase

        if (low_hit) r_d.err = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{sp: '0, phase: PH_IDLE, hold: '0, pop_data: '0,
                     pop_valid: 1'b0, ret_addr: '0, ret_valid: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sp_lo_o     = r_q.sp[BYTE_W-1:0];
    assign sp_hi_o     = r_q.sp[SP_W-1:BYTE_W];
    assign mem_addr_o  = addr_c;
    assign mem_wdata_o = wdata_c;
    assign mem_we_o    = we_c;
    assign mem_re_o    = re_c;
    assign pop_data_o  = r_q.pop_data;
    assign pop_valid_o = r_q.pop_valid;
    assign ret_addr_o  = r_q.ret_addr;
    assign ret_valid_o = r_q.ret_valid;
    assign busy_o      = (r_q.phase != PH_IDLE);
    assign stk_err_o   = r_q.err;
endmodule

// File: rtl/stk_checker.sv
module stk_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  op_i,
    input logic        sw_wr_lo_i,
    input logic        sw_wr_hi_i,
    input logic [7:0]  sp_lo_o,
    input logic [7:0]  sp_hi_o,
    input logic [15:0] mem_addr_o,
    input logic        mem_we_o,
    input logic        mem_re_o,
    input logic        busy_o,
    input logic        stk_err_o,
    input logic        pop_valid_o,
    input logic        ret_valid_o
);
    logic [15:0] sp;
    logic        acc;
    assign sp  = {sp_hi_o, sp_lo_o};
    assign acc = !busy_o && !sw_wr_lo_i && !sw_wr_hi_i;

    AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_i == 3'd1) |=> (sp == $past(sp) - 16'd1)); // R3
    AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_i == 3'd2) |=> (pop_valid_o && sp == $past(sp) + 16'd1)); // R4
    AST_CALL_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_i == 3'd3) |=> busy_o ##1 (!busy_o && sp == $past(sp, 2) - 16'd2)); // R5
    AST_RET_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && op_i == 3'd4) |=> busy_o ##1 (ret_valid_o && sp == $past(sp, 2) + 16'd2)); // R6
    AST_BUSY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> !busy_o); // R7
    AST_SW_LO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && sw_wr_lo_i && !sw_wr_hi_i) |=> (sp_hi_o == $past(sp_hi_o))); // R2
    AST_LOW_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_o && mem_addr_o <= 16'h005F) |=> stk_err_o); // R8
    AST_WE_RE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o)); // R9
endmodule

bind stack_ptr_unit stk_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .sw_wr_lo_i  (sw_wr_lo_i),
    .sw_wr_hi_i  (sw_wr_hi_i),
    .sp_lo_o     (sp_lo_o),
    .sp_hi_o     (sp_hi_o),
    .mem_addr_o  (mem_addr_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .busy_o      (busy_o),
    .stk_err_o   (stk_err_o),
    .pop_valid_o (pop_valid_o),
    .ret_valid_o (ret_valid_o)
);

// File: tb/sim_stack_ptr_unit.sv
module sim_stack_ptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [7:0]  push_data = 8'h00;
    logic [15:0] ret_in = 16'h0000;
    logic        wr_lo = 1'b0, wr_hi = 1'b0;
    logic [7:0]  wdat = 8'h00;
    logic [7:0]  sp_lo, sp_hi, mem_wdata, mem_rdata = 8'h00, pop_data;
    logic [15:0] mem_addr, ret_out;
    logic        mem_we, mem_re, pop_valid, ret_valid, busy, err;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    logic [7:0] mem [int];

    // reference model state
    int    m_sp, m_phase, m_hold, m_popd, m_reta;
    bit    m_popv, m_retv, m_err;
    string m_tag = "R1";

    always #5 clk = ~clk;

    stack_ptr_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_i(op), .push_data_i(push_data),
        .ret_addr_i(ret_in), .sw_wr_lo_i(wr_lo), .sw_wr_hi_i(wr_hi),
        .sw_wdata_i(wdat), .sp_lo_o(sp_lo), .sp_hi_o(sp_hi),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
        .mem_re_o(mem_re), .mem_rdata_i(mem_rdata), .pop_data_o(pop_data),
        .pop_valid_o(pop_valid), .ret_addr_o(ret_out), .ret_valid_o(ret_valid),
        .busy_o(busy), .stk_err_o(err)
    );

    function automatic logic [7:0] rd(int a);
        return mem.exists(a & 16'hFFFF) ? mem[a & 16'hFFFF] : 8'h00;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // expected port activity for the current model state and inputs
    task automatic exp_port(output bit we, output bit re, output int addr, output int wd);
        we = 0; re = 0; addr = m_sp; wd = 0;
        if (m_phase == 1) begin we = 1; wd = m_hold; end
        else if (m_phase == 2) begin re = 1; addr = (m_sp + 1) & 16'hFFFF; end
        else if (!(wr_lo || wr_hi)) begin
            if (op == 3'd1) begin we = 1; wd = push_data; end
            else if (op == 3'd2 || op == 3'd4) begin re = 1; addr = (m_sp + 1) & 16'hFFFF; end
            else if (op == 3'd3) begin we = 1; wd = ret_in[7:0]; end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sp = 0; m_phase = 0; m_hold = 0; m_popd = 0; m_reta = 0;
            m_popv = 0; m_retv = 0; m_err = 0; m_tag = "R1";
        end else begin
            bit ew, er; int ea, ed;
            exp_port(ew, er, ea, ed);
            m_popv = 0; m_retv = 0;
            if (ew && ea <= 16'h005F) m_err = 1;
            if (m_phase == 1) begin
                m_sp = (m_sp - 1) & 16'hFFFF; m_phase = 0; m_tag = "R5";
            end else if (m_phase == 2) begin
                m_sp = (m_sp + 1) & 16'hFFFF;
                m_reta = (m_hold << 8) | rd(m_sp); m_retv = 1; m_phase = 0; m_tag = "R6";
            end else if (wr_lo || wr_hi) begin
                if (wr_lo) m_sp = (m_sp & 16'hFF00) | wdat;
                if (wr_hi) m_sp = (m_sp & 16'h00FF) | (int'(wdat) << 8);
                m_err = 0; m_tag = "R2";
            end else if (op == 3'd1) begin
                m_sp = (m_sp - 1) & 16'hFFFF; m_tag = "R3";
            end else if (op == 3'd2) begin
                m_sp = (m_sp + 1) & 16'hFFFF; m_popd = rd(m_sp); m_popv = 1; m_tag = "R4";
            end else if (op == 3'd3) begin
                m_hold = ret_in[15:8]; m_sp = (m_sp - 1) & 16'hFFFF; m_phase = 1; m_tag = "R5";
            end else if (op == 3'd4) begin
                m_sp = (m_sp + 1) & 16'hFFFF; m_hold = rd(m_sp); m_phase = 2; m_tag = "R6";
            end else begin
                m_tag = "R9";
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
        end
    end

    // one clock: compare registered outputs, drive inputs, compare port activity
    task automatic cyc(input logic [2:0] o, input logic [7:0] pd, input logic [15:0] ra,
                       input logic lo, input logic hi, input logic [7:0] wd);
        bit ew, er; int ea, ed;
        @(negedge clk);
        chk({m_tag, " sp"}, {sp_hi, sp_lo}, m_sp);
        chk("R7 busy", busy, m_phase != 0);
        chk("R8 err", err, m_err);
        chk("R4 pop_valid", pop_valid, m_popv);
        if (m_popv) chk("R4 pop_data", pop_data, m_popd);
        chk("R6 ret_valid", ret_valid, m_retv);
        if (m_retv) chk("R6 ret_addr", ret_out, m_reta);
        op = o; push_data = pd; ret_in = ra; wr_lo = lo; wr_hi = hi; wdat = wd;
        #1;
        mem_rdata = rd(mem_addr);
        #1;
        exp_port(ew, er, ea, ed);
        chk("R9 we", mem_we, ew);
        chk("R9 re", mem_re, er);
        if (ew || er) chk({m_phase == 0 ? "R3" : "R7", " addr"}, mem_addr, ea);
        if (ew) chk("R5 wdata", mem_wdata, ed);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(3'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'h00);
    endtask
    task automatic set_sp(logic [15:0] v);
        cyc(3'd0, 8'h00, 16'h0, 1'b0, 1'b1, v[15:8]);
        cyc(3'd0, 8'h00, 16'h0, 1'b1, 1'b0, v[7:0]);
    endtask
    task automatic push(logic [7:0] d); cyc(3'd1, d, 16'h0, 1'b0, 1'b0, 8'h00); endtask
    task automatic pop();               cyc(3'd2, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00); endtask
    task automatic call(logic [15:0] a); cyc(3'd3, 8'h00, a, 1'b0, 1'b0, 8'h00); endtask
    task automatic ret();               cyc(3'd4, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00); endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 sp", {sp_hi, sp_lo}, 16'h0000);
        chk("R1 busy", busy, 0);
        chk("R1 err", err, 0);
        chk("R1 valids", {pop_valid, ret_valid}, 0);
        idle(2);
        // R2: byte-wise software load; low-only write keeps high byte
        set_sp(16'h0100);
        cyc(3'd0, 8'h00, 16'h0, 1'b1, 1'b0, 8'h40);
        idle(1);
        chk("R2 lo only", {sp_hi, sp_lo}, 16'h0140);
        set_sp(16'h0100);
        // R3 and R4: LIFO byte order
        push(8'hA1); push(8'hB2); push(8'hC3);
        pop(); pop(); pop();
        idle(1);
        // R5 and R6: frame round trip
        call(16'h1234); idle(1); ret(); idle(2);
        // nested frames mixed with data
        call(16'hABCD); idle(1); push(8'h55); call(16'h0F0E); idle(1);
        ret(); idle(1); pop(); ret(); idle(2);
        // R7: op and software write during busy are ignored
        call(16'h2222);
        cyc(3'd1, 8'h99, 16'h0, 1'b1, 1'b1, 8'h77);
        ret();
        cyc(3'd2, 8'h00, 16'h0, 1'b1, 1'b0, 8'h33);
        idle(1);
        chk("R7 sp kept", {sp_hi, sp_lo}, 16'h0100);
        // R2: software write beats a concurrent push
        cyc(3'd1, 8'hEE, 16'h0, 1'b1, 1'b0, 8'h80);
        idle(1);
        chk("R2 sw wins", {sp_hi, sp_lo}, 16'h0180);
        // R9: unused codes
        cyc(3'd5, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);
        cyc(3'd6, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);
        cyc(3'd7, 8'h00, 16'h0, 1'b0, 1'b0, 8'h00);
        idle(1);
        chk("R9 unused op", {sp_hi, sp_lo}, 16'h0180);
        // R8: floor detection
        set_sp(16'h0061);
        push(8'h01); push(8'h02); idle(1);
        chk("R8 at 0x60 clean", err, 0);
        push(8'h03); idle(1);
        chk("R8 at 0x5F flagged", err, 1);
        idle(2);
        chk("R8 sticky", err, 1);
        set_sp(16'h0060); idle(1);
        chk("R8 cleared", err, 0);
        call(16'h4321); idle(2);
        chk("R8 call second byte", err, 1);
        set_sp(16'h0200);
        ret(); idle(3);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule